// File: doc/BRIEF.md
# Hall Commutation Decoder with Direction Control

This block sits between three digitised rotor-position sensor bits and the six gate drivers of a three-phase bridge. It cleans the sensor code with a two-flop synchroniser and a stability filter. It then looks up which phase sources current and which phase sinks it. Between two conduction pairs it forces a dead band. Finally it gates the result with run, fault, PWM and current-limit controls, all synchronous to the block clock.

Reverse rotation uses the same six-entry forward table. The accepted sensor code is inverted bit by bit before the lookup. Speed control comes from an external PWM gate. That gate chops only the active low-side switch, so the active high-side switch stays fully on for the whole step. A current-limit pulse blanks the low side for the rest of the present PWM period.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_i` = 0, the accepted sensor code `hall_i` is read as bit 2 = sensor 1, bit 1 = sensor 2 and bit 0 = sensor 3. The code selects high-side/low-side pairs as follows: 101 → high phase 2, low phase 1. 100 → high 3, low 1. 110 → high 3, low 2. 010 → high 1, low 2. 011 → high 1, low 3. 001 → high 2, low 3. Output bit 0 of `hs_en_o`/`ls_en_o` is phase 1, bit 1 is phase 2, bit 2 is phase 3.
- R2: With `dir_i` = 1, each of the six pairs is selected by the bitwise inverse of its forward code. For example, 010 gives high 2, low 1.
- R3: While running, the active high-side enable stays at 1 regardless of `pwm_i`. The active low-side enable equals `pwm_i` as sampled one clock earlier.
- R4: When `ilim_i` is sampled high, every low-side enable is 0 from the next cycle on. This lasts until `pwm_i` has gone low and then risen again with `ilim_i` low. High-side enables are unaffected.
- R5: When `start_i` is sampled low or `fault_i` is sampled high, all six enables are 0 in the next cycle.
- R6: The sensor codes 000 and 111 are illegal in either direction and turn all six enables off.
- R7: Any change of the selected step or of `dir_i` turns all six enables off for exactly max(`dead_clks_i`, 1) cycles before the new pair is driven. A further change during that band restarts it.
- R8: A new sensor code takes effect only after it has been stable at the synchroniser output for `FILT_CLKS` consecutive clocks. A pulse shorter than that leaves the outputs untouched.
- R9: At most one high-side and at most one low-side enable is ever active, and never both on the same phase.
- R10: After a synchronous active-low reset all six enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_i | input | 3 | Digitised sensor bits, asynchronous |
| dir_i | input | 1 | Rotation direction, 0 forward, 1 reverse |
| start_i | input | 1 | 1 = run, 0 = stop |
| fault_i | input | 1 | Lock-protection fault, forces off |
| pwm_i | input | 1 | Duty gate from an external modulator |
| ilim_i | input | 1 | Peak-current limit flag |
| dead_clks_i | input | DT_W | Dead band length in clocks |
| hs_en_o | output | 3 | High-side gate enables, bit 0 = phase 1 |
| ls_en_o | output | 3 | Low-side gate enables, bit 0 = phase 1 |

## Verification
The hardest situation to reach is the exact length of the dead band. The sensor filter and the synchroniser add a latency that the bench should not have to model. The stimulus therefore holds PWM high, makes one step or direction change, and counts the all-off cycles between the last sample of the old pair and the first sample of the new pair. It does this for a non-zero and for a zero `dead_clks_i`. Glitch rejection is reached by a sensor pulse shorter than the filter window while the outputs are watched for any movement.

// File: rtl/hcd_pkg.sv
// Shared types for the Hall commutation decoder.
// Assumes three phases; step index 7 marks an illegal or absent code.
package hcd_pkg;

    typedef enum logic [2:0] {
        STEP_0   = 3'd0,
        STEP_1   = 3'd1,
        STEP_2   = 3'd2,
        STEP_3   = 3'd3,
        STEP_4   = 3'd4,
        STEP_5   = 3'd5,
        STEP_OFF = 3'd7
    } step_t;

    // One conduction pair: one-hot high side, one-hot low side, bit 0 = phase 1.
    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] lo;
    } gate_pair_t;

    // Identity of the present commutation state; any change starts a dead band.
    typedef struct packed {
        logic  dir;
        step_t step;
    } comm_key_t;

    localparam gate_pair_t PAIR_OFF = '{hi: 3'b000, lo: 3'b000};

endpackage

// File: rtl/hall_input_filter.sv
// Synchronises the asynchronous sensor bits with two flops, then accepts a
// code only after it has stayed unchanged for FILT_CLKS consecutive clocks.
// Assumes FILT_CLKS >= 1. Reset value 000 is an illegal code, so outputs stay off.
module hall_input_filter #(
    parameter int FILT_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    output logic [2:0] code_o
);
    localparam int CW = $clog2(FILT_CLKS + 1);

    logic [2:0]    sync1_q;
    logic [2:0]    sync2_q;
    logic [2:0]    cand_q;
    logic [CW-1:0] stable_q;
    logic [2:0]    accepted_q;

    // Two-flop synchroniser plus stability counter and accepted-code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q    <= 3'b000;
            sync2_q    <= 3'b000;
            cand_q     <= 3'b000;
            stable_q   <= '0;
            accepted_q <= 3'b000;
        end else begin
            sync1_q <= hall_i;
            sync2_q <= sync1_q;
            cand_q  <= sync2_q;
            if (sync2_q != cand_q) begin
                stable_q <= '0;
            end else if (stable_q < CW'(FILT_CLKS)) begin
                stable_q <= stable_q + 1'b1;
            end
            if ((sync2_q == cand_q) && (stable_q >= CW'(FILT_CLKS - 1))) begin
                accepted_q <= cand_q;
            end
        end
    end

    assign code_o = accepted_q;

    // R8: a newly accepted code has been present at the synchroniser output.
    assert_accept_from_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted_q != $past(accepted_q)) |-> (accepted_q == $past(sync2_q)));

    // R8: the stability counter never runs past its window.
    assert_filter_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stable_q <= CW'(FILT_CLKS));

endmodule

// File: rtl/commutation_table.sv
// Combinational lookup from an accepted sensor code and direction to a step
// index and conduction pair. Reverse is made by inverting the code before the
// single forward table. Codes 000 and 111 give STEP_OFF and no conduction.
module commutation_table
    import hcd_pkg::*;
(
    input  logic       [2:0] code_i,
    input  logic             dir_i,
    output step_t            step_o,
    output gate_pair_t       pair_o
);
    logic [2:0] eff_code;

    // Invert the code for reverse rotation.
    always_comb eff_code = dir_i ? ~code_i : code_i;

    // Forward table: source phase on the high side, sink phase on the low side.
    always_comb begin
        unique case (eff_code)
            3'b101: begin step_o = STEP_0; pair_o = '{hi: 3'b010, lo: 3'b001}; end
            3'b100: begin step_o = STEP_1; pair_o = '{hi: 3'b100, lo: 3'b001}; end
            3'b110: begin step_o = STEP_2; pair_o = '{hi: 3'b100, lo: 3'b010}; end
            3'b010: begin step_o = STEP_3; pair_o = '{hi: 3'b001, lo: 3'b010}; end
            3'b011: begin step_o = STEP_4; pair_o = '{hi: 3'b001, lo: 3'b100}; end
            3'b001: begin step_o = STEP_5; pair_o = '{hi: 3'b010, lo: 3'b100}; end
            default: begin step_o = STEP_OFF; pair_o = PAIR_OFF; end
        endcase
    end

endmodule

// File: rtl/deadtime_sequencer.sv
// Holds the present conduction pair. On any change of step or direction it
// drives no pair for max(dead_clks_i,1) clocks, then takes the new pair.
// Assumes the target pair depends only on the key.
module deadtime_sequencer
    import hcd_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  comm_key_t         key_i,
    input  gate_pair_t        target_i,
    input  logic [DT_W-1:0]   dead_clks_i,
    output gate_pair_t        pair_o
);
    comm_key_t        key_q;
    logic [DT_W-1:0]  wait_q;
    gate_pair_t       pair_q;

    // Detect key changes, run the dead band counter, then load the new pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '{dir: 1'b0, step: STEP_OFF};
            wait_q <= '0;
            pair_q <= PAIR_OFF;
        end else if (key_i != key_q) begin
            key_q  <= key_i;
            pair_q <= PAIR_OFF;
            wait_q <= (dead_clks_i == '0) ? '0 : dead_clks_i - 1'b1;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end else begin
            pair_q <= target_i;
        end
    end

    assign pair_o = pair_q;

    // R7: the cycle after a change of step or direction carries no pair.
    assert_change_blanks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_i != key_q) |=> (pair_q == PAIR_OFF));

    // R7: a pair only appears when the key has stayed put.
    assert_pair_after_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pair_q != PAIR_OFF) && ($past(pair_q) == PAIR_OFF)) |-> $stable(key_q));

endmodule

// File: rtl/bridge_gate_stage.sv
// Registered output stage. The high side follows the pair while running; the
// low side is also gated by the PWM input and by a current-limit latch that
// holds until the next PWM rising edge. Assumes PWM, limit, start and fault
// are synchronous to clk.
module bridge_gate_stage
    import hcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  gate_pair_t  pair_i,
    input  logic        start_i,
    input  logic        fault_i,
    input  logic        pwm_i,
    input  logic        ilim_i,
    output logic [2:0]  hs_en_o,
    output logic [2:0]  ls_en_o
);
    logic       run;
    logic       pwm_q;
    logic       limit_hold_q;
    logic       ls_allow;
    logic [2:0] hs_q;
    logic [2:0] ls_q;

    // Run when started and no fault; low side also needs PWM and no limit.
    always_comb begin
        run      = start_i && !fault_i;
        ls_allow = run && pwm_i && !ilim_i && !limit_hold_q;
    end

    // Current-limit latch: set by the flag, cleared on the next PWM rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q        <= 1'b0;
            limit_hold_q <= 1'b0;
        end else begin
            pwm_q <= pwm_i;
            if (ilim_i) begin
                limit_hold_q <= 1'b1;
            end else if (pwm_i && !pwm_q) begin
                limit_hold_q <= 1'b0;
            end
        end
    end

    // Output registers for the six gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 3'b000;
            ls_q <= 3'b000;
        end else begin
            hs_q <= run ? pair_i.hi : 3'b000;
            ls_q <= ls_allow ? pair_i.lo : 3'b000;
        end
    end

    assign hs_en_o = hs_q;
    assign ls_en_o = ls_q;

    // R9: at most one high-side and one low-side switch at a time.
    assert_hs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_q));
    assert_ls_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ls_q));

    // R9: never both switches of one phase.
    assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q & ls_q) == 3'b000);

    // R5: stop or fault clears every enable in the next cycle.
    assert_stop_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i || fault_i) |=> (hs_q == 3'b000 && ls_q == 3'b000));

    // R4: the limit flag blanks the low side in the next cycle.
    assert_limit_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_i |=> (ls_q == 3'b000));

    // R3: low side never conducts in a cycle after PWM was low.
    assert_pwm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_i |=> (ls_q == 3'b000));

endmodule

// File: rtl/hall_commutator.sv
// Top level: sensor filter, commutation lookup, dead band sequencer and
// registered gate stage. All control inputs except hall_i are synchronous.
module hall_commutator
    import hcd_pkg::*;
#(
    parameter int FILT_CLKS = 4,
    parameter int DT_W      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      hall_i,
    input  logic            dir_i,
    input  logic            start_i,
    input  logic            fault_i,
    input  logic            pwm_i,
    input  logic            ilim_i,
    input  logic [DT_W-1:0] dead_clks_i,
    output logic [2:0]      hs_en_o,
    output logic [2:0]      ls_en_o
);
    logic [2:0]  code;
    step_t       step;
    gate_pair_t  target;
    gate_pair_t  active;
    comm_key_t   key;

    hall_input_filter #(.FILT_CLKS(FILT_CLKS)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .hall_i (hall_i),
        .code_o (code)
    );

    commutation_table u_table (
        .code_i (code),
        .dir_i  (dir_i),
        .step_o (step),
        .pair_o (target)
    );

    // Key that identifies the commutation state for the dead band logic.
    always_comb key = '{dir: dir_i, step: step};

    deadtime_sequencer #(.DT_W(DT_W)) u_deadtime (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_i       (key),
        .target_i    (target),
        .dead_clks_i (dead_clks_i),
        .pair_o      (active)
    );

    bridge_gate_stage u_gates (
        .clk     (clk),
        .rst_n   (rst_n),
        .pair_i  (active),
        .start_i (start_i),
        .fault_i (fault_i),
        .pwm_i   (pwm_i),
        .ilim_i  (ilim_i),
        .hs_en_o (hs_en_o),
        .ls_en_o (ls_en_o)
    );

    // R6: an illegal accepted code never yields a conduction pair.
    assert_illegal_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((code == 3'b000) || (code == 3'b111)) |=> (active == PAIR_OFF));

endmodule

// File: tb/test_hall_commutator.sv
// Directed bench: one task per scenario, each checking its own results.
module test_hall_commutator;
    localparam int FILT = 4;
    localparam int DTW  = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2:0]     hall_i;
    logic           dir_i, start_i, fault_i, pwm_i, ilim_i;
    logic [DTW-1:0] dead_clks_i;
    logic [2:0]     hs_en_o, ls_en_o;

    int checks = 0;
    int fails  = 0;
    int settle_cycles;

    always #2 clk = ~clk;

    hall_commutator #(.FILT_CLKS(FILT), .DT_W(DTW)) i_hall_commutator (
        .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .dir_i(dir_i),
        .start_i(start_i), .fault_i(fault_i), .pwm_i(pwm_i), .ilim_i(ilim_i),
        .dead_clks_i(dead_clks_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
    );

    // Expected {hi, lo} from the requirement tables (R1 forward, R2 reverse).
    function automatic logic [5:0] expect_pair(input logic d, input logic [2:0] h);
        case ({d, h})
            4'b0101: return {3'b010, 3'b001};
            4'b0100: return {3'b100, 3'b001};
            4'b0110: return {3'b100, 3'b010};
            4'b0010: return {3'b001, 3'b010};
            4'b0011: return {3'b001, 3'b100};
            4'b0001: return {3'b010, 3'b100};
            4'b1010: return {3'b010, 3'b001};
            4'b1011: return {3'b100, 3'b001};
            4'b1001: return {3'b100, 3'b010};
            4'b1101: return {3'b001, 3'b010};
            4'b1100: return {3'b001, 3'b100};
            4'b1110: return {3'b010, 3'b100};
            default: return 6'b000000;
        endcase
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual hs/ls=%b_%b expected %b_%b",
                     req, act[5:3], act[2:0], exp[5:3], exp[2:0]);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input logic [2:0] h, input logic d);
        @(negedge clk);
        hall_i = h;
        dir_i  = d;
        repeat (settle_cycles) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // R10: reset state.
    task automatic t_reset();
        rst_n = 1'b0; hall_i = 3'b101; dir_i = 1'b0; start_i = 1'b1;
        fault_i = 1'b0; pwm_i = 1'b1; ilim_i = 1'b0; dead_clks_i = 6'd3;
        settle_cycles = FILT + 6 + 12;
        repeat (4) @(negedge clk);
        check("R10 reset", {hs_en_o, ls_en_o}, 6'b0);
        rst_n = 1'b1;
    endtask

    // R1: forward table for all six codes.
    task automatic t_forward();
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int i = 0; i < 6; i++) begin
            settle(codes[i], 1'b0);
            check($sformatf("R1 fwd code %b", codes[i]), {hs_en_o, ls_en_o}, expect_pair(1'b0, codes[i]));
        end
    endtask

    // R2: reverse uses inverted codes.
    task automatic t_reverse();
        logic [2:0] codes [6] = '{3'b010, 3'b011, 3'b001, 3'b101, 3'b100, 3'b110};
        for (int i = 0; i < 6; i++) begin
            settle(codes[i], 1'b1);
            check($sformatf("R2 rev code %b", codes[i]), {hs_en_o, ls_en_o}, expect_pair(1'b1, codes[i]));
        end
    endtask

    // R6: illegal codes in both directions.
    task automatic t_illegal();
        settle(3'b000, 1'b0); check("R6 000 fwd", {hs_en_o, ls_en_o}, 6'b0);
        settle(3'b111, 1'b0); check("R6 111 fwd", {hs_en_o, ls_en_o}, 6'b0);
        settle(3'b111, 1'b1); check("R6 111 rev", {hs_en_o, ls_en_o}, 6'b0);
        settle(3'b000, 1'b1); check("R6 000 rev", {hs_en_o, ls_en_o}, 6'b0);
    endtask

    // R3: PWM chops only the low side.
    task automatic t_pwm();
        logic [5:0] p;
        settle(3'b110, 1'b0);
        p = expect_pair(1'b0, 3'b110);
        pwm_i = 1'b0; @(negedge clk);
        check("R3 pwm low", {hs_en_o, ls_en_o}, {p[5:3], 3'b000});
        @(negedge clk);
        check("R3 pwm low hold", {hs_en_o, ls_en_o}, {p[5:3], 3'b000});
        pwm_i = 1'b1; @(negedge clk);
        check("R3 pwm high", {hs_en_o, ls_en_o}, p);
    endtask

    // R4: limit blanks the low side until the next PWM rise.
    task automatic t_ilim();
        logic [5:0] p;
        settle(3'b011, 1'b0);
        p = expect_pair(1'b0, 3'b011);
        ilim_i = 1'b1; @(negedge clk);
        ilim_i = 1'b0;
        check("R4 limit blank", {hs_en_o, ls_en_o}, {p[5:3], 3'b000});
        repeat (4) @(negedge clk);
        check("R4 rest of period", {hs_en_o, ls_en_o}, {p[5:3], 3'b000});
        pwm_i = 1'b0; @(negedge clk);
        pwm_i = 1'b1; repeat (3) @(negedge clk);
        check("R4 next period", {hs_en_o, ls_en_o}, p);
    endtask

    // R5: stop and fault.
    task automatic t_stop_fault();
        logic [5:0] p;
        settle(3'b001, 1'b0);
        p = expect_pair(1'b0, 3'b001);
        start_i = 1'b0; @(negedge clk);
        check("R5 stop", {hs_en_o, ls_en_o}, 6'b0);
        start_i = 1'b1; @(negedge clk);
        check("R5 restart", {hs_en_o, ls_en_o}, p);
        fault_i = 1'b1; @(negedge clk);
        check("R5 fault", {hs_en_o, ls_en_o}, 6'b0);
        repeat (3) @(negedge clk);
        check("R5 fault hold", {hs_en_o, ls_en_o}, 6'b0);
        fault_i = 1'b0; @(negedge clk);
        check("R5 fault clear", {hs_en_o, ls_en_o}, p);
    endtask

    // R7: count all-off cycles between old and new pair.
    task automatic measure_dead(input string req, input logic [2:0] h, input logic d,
                                input int exp_zero);
        logic [5:0] oldp, newp;
        int zeros = 0;
        oldp = {hs_en_o, ls_en_o};
        newp = expect_pair(d, h);
        @(negedge clk);
        hall_i = h; dir_i = d;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if ({hs_en_o, ls_en_o} == 6'b0) zeros++;
            else if ({hs_en_o, ls_en_o} != oldp || zeros > 0) break;
        end
        check_int({req, " zero cycles"}, zeros, exp_zero);
        check({req, " new pair"}, {hs_en_o, ls_en_o}, newp);
    endtask

    task automatic t_deadtime();
        dead_clks_i = 6'd5;
        settle(3'b101, 1'b0);
        measure_dead("R7 step change dt5", 3'b100, 1'b0, 5);
        measure_dead("R7 dir change dt5", 3'b100, 1'b1, 5);
        dead_clks_i = 6'd0;
        repeat (8) @(negedge clk);
        measure_dead("R7 step change dt0", 3'b110, 1'b1, 1);
        dead_clks_i = 6'd3;
    endtask

    // R8: short glitch ignored, long change accepted.
    task automatic t_filter();
        logic [5:0] p;
        int moved = 0;
        settle(3'b101, 1'b0);
        p = expect_pair(1'b0, 3'b101);
        hall_i = 3'b100; repeat (FILT - 2) @(negedge clk);
        hall_i = 3'b101;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if ({hs_en_o, ls_en_o} != p) moved++;
        end
        check_int("R8 glitch ignored", moved, 0);
        hall_i = 3'b100; repeat (settle_cycles) @(negedge clk);
        check("R8 stable code accepted", {hs_en_o, ls_en_o}, expect_pair(1'b0, 3'b100));
    endtask

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_illegal();
        t_pwm();
        t_ilim();
        t_stop_fault();
        t_deadtime();
        t_filter();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule